// File: doc/BRIEF.md
# SPI Target Interface with Word-Packed Byte FIFOs

This block is the peripheral side of an SPI link. A host CPU reaches it through a small register port. Through that port it picks one of the four clock modes and the bit order of each direction, and enables transmit and receive. It queues outgoing data as 32-bit words and collects incoming data as 32-bit words. On the serial side the block never clocks logic from SCK. It passes SCK, chip select and MOSI through two-flop synchronizers and finds the clock edges with the system clock, so SCK must run at no more than a quarter of the system clock rate.

Each direction has a 512-byte queue. A word written by the host is split into four serial bytes, low byte first. Serial bytes that arrive are packed back into words, with the first byte received landing in the low byte. When chip select goes inactive, the block posts completion events in a status register. The host reads that register and clears it by writing the bits back. An interrupt line combines status with an enable register and a mask register. A soft-reset command empties both queues and idles the shifter without touching the settings.

Top module: `spi_target`

## Requirements
- R1: After reset, the config, enable, mask and status registers read 0, `irq` is low and `miso` is low.
- R2: The config register at offset 0x10 reads back what was written. Its bits are: 0 receive enable, 1 transmit enable, 2 clock idle level (CPOL), 3 clock phase (CPHA), 4 receive MSB-first, 5 transmit MSB-first, 6 receive word byte-swap, 7 transmit word byte-swap.
- R3: A word written to offset 0x18 queues four bytes, and they are sent bits 7:0 first. Each byte goes out MSB-first when config bit 5 is 1 and LSB-first when it is 0.
- R4: A read of offset 0x14 pops up to four received bytes. The earliest byte is in bits 7:0. A byte lane with no data reads 0, so an empty queue reads 0. Bit order within a byte follows config bit 4.
- R5: All four modes work. With CPHA=0, data is captured on the edge that leaves the CPOL level and MISO changes on the edge that returns to it. With CPHA=1, MISO changes on the edge that leaves the CPOL level and data is captured on the edge that returns.
- R6: While transmit is disabled, or when the transmit queue is empty, the block shifts out zeros.
- R7: The receive queue holds 512 bytes. A byte that arrives while it is full is dropped, and status bit 3 (overflow) is set.
- R8: Writing 1 to bit 0 at offset 0x40 empties both queues and returns the shifter to idle. The config register keeps its value.
- R9: Status at offset 0x08 has bit 0 command-invalid (set by a `cmd_bad` pulse), bit 1 frame-done, bit 2 data-done and bit 3 overflow. Writing 1 to a bit at offset 0x04 clears that bit. A new event in the same cycle wins over the clear.
- R10: `irq` is high exactly when some status bit is also set in the enable register (0x00) and in the mask register (0x0C).
- R11: When chip select goes inactive at the end of a frame, frame-done is set. Data-done is set only if at least one whole byte moved during that frame.
- R12: Config bit 7 reverses the byte order of each word written for transmit. Config bit 6 reverses the byte order of each word read from receive.
- R13: While receive is disabled, incoming bytes are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at 0x14) |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high |
| sck | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| cmd_bad | input | 1 | One-cycle pulse that sets the command-invalid status bit |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the reset state, that the receive queue never exceeds its depth, that a soft reset empties both queues, and that status bits are set and cleared as required. They also check that `irq` stays low while nothing is enabled. Only the bench's scenarios can show the serial behaviour. That covers correct bit and byte order in all four modes, the effect of each swap bit, zero fill when transmit has no data, exactly which byte is dropped on overflow, and data-done staying clear for a frame that carried no clocks.

// File: rtl/spi_tgt_pkg.sv
// Shared offsets, bit positions and helpers for the SPI target block.
package spi_tgt_pkg;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned NSRC   = 4;

    localparam logic [ADDR_W-1:0] A_IRQ_EN   = 7'h00;
    localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 7'h04;
    localparam logic [ADDR_W-1:0] A_IRQ_ST   = 7'h08;
    localparam logic [ADDR_W-1:0] A_IRQ_MASK = 7'h0C;
    localparam logic [ADDR_W-1:0] A_CFG      = 7'h10;
    localparam logic [ADDR_W-1:0] A_RXD      = 7'h14;
    localparam logic [ADDR_W-1:0] A_TXD      = 7'h18;
    localparam logic [ADDR_W-1:0] A_SRST     = 7'h40;

    localparam int C_RX_EN   = 0;
    localparam int C_TX_EN   = 1;
    localparam int C_CPOL    = 2;
    localparam int C_CPHA    = 3;
    localparam int C_RX_MSB  = 4;
    localparam int C_TX_MSB  = 5;
    localparam int C_RX_SWAP = 6;
    localparam int C_TX_SWAP = 7;

    localparam int S_CMD  = 0;
    localparam int S_XFER = 1;
    localparam int S_DATA = 2;
    localparam int S_OVF  = 3;

    // Reverse the byte order of a 32-bit word.
    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/spi_tgt_sync.sv
// Two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes each input is held long enough to be seen (slow relative to clk).
module spi_tgt_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spi_tgt_fifo.sv
// Byte FIFO with a multi-byte push port and a multi-byte peek/pop port.
// Assumes DEPTH is a power of two, that the caller never pushes more than
// the free space nor pops more than the count, and that flush wins over both.
module spi_tgt_fifo #(
    parameter int unsigned DEPTH      = 512,
    parameter int unsigned PUSH_LANES = 4,
    parameter int unsigned POP_LANES  = 1,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = AW + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [CW-1:0]           push_n,
    input  logic [PUSH_LANES*8-1:0] push_data,
    input  logic [CW-1:0]           pop_n,
    output logic [POP_LANES*8-1:0]  peek,
    output logic [CW-1:0]           count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    // Storage write: one byte per active push lane.
    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_LANES; i++) begin
            if (!flush && CW'(i) < push_n)
                mem[wr_ptr + AW'(i)] <= push_data[i*8 +: 8];
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + push_n[AW-1:0];
            rd_ptr <= rd_ptr + pop_n[AW-1:0];
            count  <= count + push_n - pop_n;
        end
    end

    // Oldest bytes presented lane by lane.
    always_comb begin
        for (int i = 0; i < POP_LANES; i++)
            peek[i*8 +: 8] = mem[rd_ptr + AW'(i)];
    end
endmodule

// File: rtl/spi_tgt_shift.sv
// Serial engine for the SPI target, running on synchronized SCK/CS/MOSI.
// Finds SCK edges by comparing against the previous sample, so SCK must be at
// most clk/4. Handles all CPOL/CPHA modes and per-direction bit order.
module spi_tgt_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       tx_msb,
    input  logic       rx_msb,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       sck_s,
    input  logic       cs_n_s,
    input  logic       mosi_s,
    input  logic       tx_avail,
    input  logic [7:0] tx_byte,
    output logic       tx_pop,
    output logic       rx_push,
    output logic [7:0] rx_byte,
    output logic       miso,
    output logic       end_any,
    output logic       end_data
);
    logic       sck_q, cs_q, active, load_pend, got_byte;
    logic [7:0] tx_sh, rx_sh, rx_next;
    logic [2:0] tx_idx, rx_idx;
    logic       toggle, lead, trail, cs_fall, cs_rise, samp, drive, load, take;

    // Previous samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
        end
    end

    // Edge classification and load decision.
    always_comb begin
        toggle  = sck_s ^ sck_q;
        lead    = toggle && (sck_s != cpol);
        trail   = toggle && (sck_s == cpol);
        cs_fall = cs_q && !cs_n_s;
        cs_rise = !cs_q && cs_n_s;
        samp    = active && (cpha ? trail : lead);
        drive   = active && (cpha ? lead : trail);
        load    = (cs_fall && !cpha) || (drive && !cpha && tx_idx == 3'd7)
                || (drive && cpha && load_pend);
        take    = tx_en && tx_avail;
        tx_pop  = load && take && !flush;
        rx_next = rx_msb ? {rx_sh[6:0], mosi_s} : {mosi_s, rx_sh[7:1]};
        miso    = active && (tx_msb ? tx_sh[3'd7 - tx_idx] : tx_sh[tx_idx]);
    end

    // Frame state, transmit shifter and receive assembler.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            active    <= 1'b0;
            load_pend <= 1'b0;
            got_byte  <= 1'b0;
            tx_sh     <= '0;
            tx_idx    <= '0;
            rx_sh     <= '0;
            rx_idx    <= '0;
            rx_push   <= 1'b0;
            rx_byte   <= '0;
            end_any   <= 1'b0;
            end_data  <= 1'b0;
        end else begin
            rx_push  <= 1'b0;
            end_any  <= 1'b0;
            end_data <= 1'b0;
            if (cs_fall) begin
                active    <= 1'b1;
                rx_idx    <= '0;
                got_byte  <= 1'b0;
                load_pend <= cpha;
            end
            if (load) begin
                tx_sh     <= take ? tx_byte : 8'h00;
                tx_idx    <= '0;
                load_pend <= 1'b0;
            end else if (drive) begin
                tx_idx <= tx_idx + 3'd1;
            end
            if (samp) begin
                rx_sh  <= rx_next;
                rx_idx <= rx_idx + 3'd1;
                if (rx_idx == 3'd7) begin
                    got_byte <= 1'b1;
                    rx_push  <= rx_en;
                    rx_byte  <= rx_next;
                    if (cpha) load_pend <= 1'b1;
                end
            end
            if (cs_rise && active) begin
                active   <= 1'b0;
                end_any  <= 1'b1;
                end_data <= got_byte;
            end
        end
    end
endmodule

// File: rtl/spi_target.sv
// SPI target top: register port, word packing, status/interrupt logic.
// Assumes SCK <= clk/4 and FIFO_BYTES a power of two. reg_rdata is valid in
// the cycle reg_rd is high; a read of the RX data offset pops at that edge.
module spi_target
    import spi_tgt_pkg::*;
#(
    parameter int unsigned FIFO_BYTES = 512,
    localparam int unsigned CW = $clog2(FIFO_BYTES) + 1,
    localparam int unsigned WB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    input  logic              cmd_bad,
    output logic              irq
);
    logic [7:0]      cfg;
    logic [NSRC-1:0] irq_en, irq_mask, irq_st;
    logic            flush, sck_s, cs_n_s, mosi_s;
    logic [CW-1:0]   tx_cnt, rx_cnt, tx_push_n, tx_pop_n, rx_push_n, rx_pop_n, rx_avail;
    logic [31:0]     tx_word, rx_peek, rx_word, rx_fill;
    logic [7:0]      tx_peek, rx_byte;
    logic            tx_pop, rx_push, rx_ok, sh_end_any, sh_end_data;

    spi_tgt_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sck, cs_n, mosi}), .q({sck_s, cs_n_s, mosi_s})
    );

    // Soft reset, word split/pack and queue handshakes.
    always_comb begin
        flush     = reg_wr && reg_addr == A_SRST && reg_wdata[0];
        tx_word   = cfg[C_TX_SWAP] ? swap32(reg_wdata) : reg_wdata;
        tx_push_n = (reg_wr && reg_addr == A_TXD && (CW'(FIFO_BYTES) - tx_cnt) >= CW'(WB))
                    ? CW'(WB) : '0;
        tx_pop_n  = CW'(tx_pop);
        rx_ok     = rx_push && rx_cnt != CW'(FIFO_BYTES);
        rx_push_n = CW'(rx_ok);
        rx_avail  = (rx_cnt >= CW'(WB)) ? CW'(WB) : rx_cnt;
        rx_pop_n  = (reg_rd && reg_addr == A_RXD) ? rx_avail : '0;
        for (int i = 0; i < WB; i++)
            rx_fill[i*8 +: 8] = (CW'(i) < rx_cnt) ? rx_peek[i*8 +: 8] : 8'h00;
        rx_word   = cfg[C_RX_SWAP] ? swap32(rx_fill) : rx_fill;
    end

    spi_tgt_fifo #(.DEPTH(FIFO_BYTES), .PUSH_LANES(WB), .POP_LANES(1)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_n(tx_push_n), .push_data(tx_word),
        .pop_n(tx_pop_n), .peek(tx_peek), .count(tx_cnt)
    );

    spi_tgt_fifo #(.DEPTH(FIFO_BYTES), .PUSH_LANES(1), .POP_LANES(WB)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_n(rx_push_n), .push_data(rx_byte),
        .pop_n(rx_pop_n), .peek(rx_peek), .count(rx_cnt)
    );

    spi_tgt_shift u_shift (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cpol(cfg[C_CPOL]), .cpha(cfg[C_CPHA]), .tx_msb(cfg[C_TX_MSB]), .rx_msb(cfg[C_RX_MSB]),
        .tx_en(cfg[C_TX_EN]), .rx_en(cfg[C_RX_EN]),
        .sck_s(sck_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
        .tx_avail(tx_cnt != '0), .tx_byte(tx_peek), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte), .miso(miso),
        .end_any(sh_end_any), .end_data(sh_end_data)
    );

    // Host-written settings; soft reset leaves them alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            irq_en   <= '0;
            irq_mask <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CFG)      cfg      <= reg_wdata[7:0];
            if (reg_addr == A_IRQ_EN)   irq_en   <= reg_wdata[NSRC-1:0];
            if (reg_addr == A_IRQ_MASK) irq_mask <= reg_wdata[NSRC-1:0];
        end
    end

    // Event status: write-one-to-clear, new events take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_st <= '0;
        end else begin
            logic [NSRC-1:0] nxt;
            nxt = irq_st;
            if (reg_wr && reg_addr == A_IRQ_CLR) nxt = nxt & ~reg_wdata[NSRC-1:0];
            if (cmd_bad)             nxt[S_CMD]  = 1'b1;
            if (sh_end_any)          nxt[S_XFER] = 1'b1;
            if (sh_end_data)         nxt[S_DATA] = 1'b1;
            if (rx_push && !rx_ok)   nxt[S_OVF]  = 1'b1;
            irq_st <= nxt;
        end
    end

    // Interrupt request.
    assign irq = |(irq_st & irq_en & irq_mask);

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_IRQ_EN:   reg_rdata = {{(32-NSRC){1'b0}}, irq_en};
            A_IRQ_ST:   reg_rdata = {{(32-NSRC){1'b0}}, irq_st};
            A_IRQ_MASK: reg_rdata = {{(32-NSRC){1'b0}}, irq_mask};
            A_CFG:      reg_rdata = {24'h0, cfg};
            A_RXD:      reg_rdata = rx_word;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_target_chk.sv
// Property checker for spi_target, attached by bind.
module spi_target_chk
    import spi_tgt_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned CW = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wd0,
    input logic              wd2,
    input logic              cmd_bad,
    input logic              irq,
    input logic [NSRC-1:0]   st,
    input logic [NSRC-1:0]   en,
    input logic [CW-1:0]     tx_cnt,
    input logic [CW-1:0]     rx_cnt,
    input logic              data_end
);
    logic was_rst;

    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: first cycle out of reset shows the cleared state
    always @(posedge clk) begin
        if (rst_n && was_rst)
            a_r1_reset_state: assert (st == '0 && !irq && tx_cnt == '0 && rx_cnt == '0);
    end

    a_r7_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SRST && wd0) |=> (tx_cnt == '0 && rx_cnt == '0));

    a_r9_cmd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bad |=> st[S_CMD]);

    a_r9_clear_data: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_IRQ_CLR && wd2 && !data_end) |=> !st[S_DATA]);

    a_r10_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);
endmodule

bind spi_target spi_target_chk #(.DEPTH(FIFO_BYTES), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wd0(reg_wdata[0]), .wd2(reg_wdata[2]), .cmd_bad(cmd_bad), .irq(irq),
    .st(irq_st), .en(irq_en), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .data_end(sh_end_data)
);

// File: tb/test_spi_target.sv
`timescale 1ns/1ps
module test_spi_target;
    localparam int H = 8;  // SCK half period in clk cycles

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso, cmd_bad = 1'b0, irq;
    logic        m_cpol = 1'b0, m_cpha = 1'b0;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    spi_target i_spi_target (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .cmd_bad(cmd_bad), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  cfg;
        logic [31:0] tx, mosi_w, exp_miso, exp_rx;
    } vec_t;

    // cfg bits: 0 rx_en,1 tx_en,2 cpol,3 cpha,4 rx_msb,5 tx_msb,6 rx_swap,7 tx_swap
    localparam vec_t VECS [8] = '{
        '{8'h33, 32'hA1B2C3D4, 32'h5E6F7081, 32'hA1B2C3D4, 32'h5E6F7081},
        '{8'h37, 32'h0F1E2D3C, 32'h96A5B4C3, 32'h0F1E2D3C, 32'h96A5B4C3},
        '{8'h0B, 32'h80402010, 32'h01020408, 32'h80402010, 32'h01020408},
        '{8'h3F, 32'hCAFEF00D, 32'h12345678, 32'hCAFEF00D, 32'h12345678},
        '{8'h13, 32'h6D5C4B3A, 32'hF1E2D3C4, 32'h6D5C4B3A, 32'hF1E2D3C4},
        '{8'hC3, 32'h11223344, 32'hDEADBEEF, 32'h44332211, 32'hEFBEADDE},
        '{8'h31, 32'hFFFFFFFF, 32'h0BADF00D, 32'h00000000, 32'h0BADF00D},
        '{8'h32, 32'h55AA55AA, 32'h77665544, 32'h55AA55AA, 32'h00000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_mode(input logic [7:0] c);
        wr(7'h10, {24'h0, c});
        m_cpol = c[2]; m_cpha = c[3];
        sck = m_cpol;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (4*H) @(negedge clk);
    endtask

    // One byte as controller: out_msb = order target receives, in_msb = order it sends.
    task automatic spi_byte(input logic [7:0] ob, input logic out_msb, input logic in_msb,
                            output logic [7:0] ib);
        for (int b = 0; b < 8; b++) begin
            int k = out_msb ? 7 - b : b;
            int j = in_msb ? 7 - b : b;
            if (!m_cpha) begin
                mosi = ob[k];
                repeat (H) @(negedge clk);
                sck = ~m_cpol;
                ib[j] = miso;
                repeat (H) @(negedge clk);
                sck = m_cpol;
            end else begin
                sck = ~m_cpol;
                mosi = ob[k];
                repeat (H) @(negedge clk);
                sck = m_cpol;
                ib[j] = miso;
                repeat (H) @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, mw;
        logic [7:0]  g;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 0);
        chk("R1 miso", {31'h0, miso}, 0);
        rd(7'h08, r); chk("R1 status", r, 0);
        rd(7'h10, r); chk("R1 cfg", r, 0);
        rd(7'h00, r); chk("R1 enable", r, 0);

        // R2 config readback
        wr(7'h10, 32'hA5); rd(7'h10, r); chk("R2 cfg readback", r, 32'hA5);

        // R9 / R10 status, clear and interrupt gating
        wr(7'h10, 32'h0);
        @(negedge clk); cmd_bad = 1'b1; @(negedge clk); cmd_bad = 1'b0;
        rd(7'h08, r); chk("R9 cmd-invalid bit0", r, 32'h1);
        chk("R10 irq off without enable", {31'h0, irq}, 0);
        wr(7'h00, 32'h1); wr(7'h0C, 32'h0); #1;
        chk("R10 irq off without mask", {31'h0, irq}, 0);
        wr(7'h0C, 32'h1); #1;
        chk("R10 irq on", {31'h0, irq}, 1);
        wr(7'h04, 32'h1); #1;
        rd(7'h08, r); chk("R9 clear bit0", r, 0);
        chk("R10 irq after clear", {31'h0, irq}, 0);

        // R11 empty frame: frame-done only
        set_mode(8'h33);
        cs_begin(); cs_end();
        rd(7'h08, r); chk("R11 empty frame status", r, 32'h2);
        wr(7'h04, 32'hF);

        // Vector table: R3 R4 R5 R6 R12 R13 R11
        for (int v = 0; v < 8; v++) begin
            wr(7'h40, 32'h1);
            set_mode(VECS[v].cfg);
            wr(7'h18, VECS[v].tx);
            cs_begin();
            for (int k = 0; k < 4; k++) begin
                spi_byte(VECS[v].mosi_w[8*k +: 8], VECS[v].cfg[4], VECS[v].cfg[5], g);
                mw[8*k +: 8] = g;
            end
            cs_end();
            chk($sformatf("R3 R5 R6 R12 miso word v%0d", v), mw, VECS[v].exp_miso);
            rd(7'h14, r);
            chk($sformatf("R4 R5 R12 R13 rx word v%0d", v), r, VECS[v].exp_rx);
            rd(7'h08, r);
            chk($sformatf("R11 data-done v%0d", v), r & 32'h6, 32'h6);
            wr(7'h04, 32'hF);
        end

        // R4 short frame: unused lanes read 0, empty queue reads 0
        wr(7'h40, 32'h1);
        set_mode(8'h31);
        cs_begin();
        spi_byte(8'h5A, 1'b1, 1'b1, g);
        spi_byte(8'hC3, 1'b1, 1'b1, g);
        cs_end();
        rd(7'h14, r); chk("R4 partial word", r, 32'h0000C35A);
        rd(7'h14, r); chk("R4 empty read", r, 0);

        // R8 soft reset empties queues, keeps config; R6 empty TX sends zeros
        set_mode(8'h33);
        wr(7'h18, 32'hFFFFFFFF);
        cs_begin(); spi_byte(8'h77, 1'b1, 1'b1, g); cs_end();
        wr(7'h40, 32'h1);
        rd(7'h14, r); chk("R8 rx flushed", r, 0);
        rd(7'h10, r); chk("R8 cfg kept", r, 32'h33);
        wr(7'h18, 32'hFFFFFFFF);
        wr(7'h40, 32'h1);
        cs_begin(); spi_byte(8'h00, 1'b1, 1'b1, g); cs_end();
        chk("R8 R6 tx flushed sends zero", {24'h0, g}, 0);
        wr(7'h04, 32'hF);

        // R7 overflow at 513th byte
        wr(7'h40, 32'h1);
        set_mode(8'h31);
        cs_begin();
        for (int i = 0; i < 512; i++) spi_byte(i[7:0], 1'b1, 1'b1, g);
        repeat (H) @(negedge clk);
        rd(7'h08, r); chk("R7 no overflow at full", r & 32'h8, 0);
        spi_byte(8'hEE, 1'b1, 1'b1, g);
        repeat (2*H) @(negedge clk);
        rd(7'h08, r); chk("R7 overflow set", r & 32'h8, 32'h8);
        cs_end();
        rd(7'h14, r); chk("R7 first word", r, 32'h03020100);
        for (int i = 1; i < 127; i++) rd(7'h14, r);
        rd(7'h14, r); chk("R7 last stored word", r, 32'hFFFEFDFC);
        rd(7'h14, r); chk("R7 extra byte dropped", r, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule